// File: doc/BRIEF.md
# Instruction Prefetch Queue with Bus Arbitration

This block sits between an execution unit and a bus sequencer. It keeps a small first-in first-out store of instruction bytes that were read ahead of need. It forms each 20-bit fetch address from a 16-bit code segment value and a 16-bit fetch offset. The consumer takes one byte per pop from the output end. While the store has room, the block issues word-wide fetch cycles to the bus sequencer. Operand read and write requests from the execution side take priority over prefetching, but they never cut a fetch cycle short.

A control transfer (branch, jump, call or return) is signalled by a one-cycle flush that carries a new segment and offset. The flush empties the store at once. Any fetch that is still on the bus finishes there, but its data is dropped. Fetching then resumes at the target. When the target offset is odd, the first fetch reads a single byte so that all later fetches are word aligned.

The bus handshake is a level request held until a one-cycle completion pulse. For a fetch, read data is taken from the aligned word: the even address supplies the low byte and the odd address supplies the high byte.

Top module: `prefetch_queue`

## Requirements
- R1: The store holds at most DEPTH (default 6) bytes. Bytes leave in the order of their addresses, one byte per cycle in which `q_pop` is high and `q_valid` is high.
- R2: A new fetch cycle begins only when at least two byte slots are free and no operand request is pending. When both are possible at a cycle boundary, the operand cycle is started first.
- R3: A fetch from an even offset reads one 16-bit word. It queues the low byte `bus_rdata[7:0]` first and the high byte `bus_rdata[15:8]` second, then advances the offset by 2.
- R4: Once a fetch cycle has started, it runs until `bus_done`, even if an operand request arrives. `bus_req` and `bus_addr` stay constant until that pulse, and the operand cycle follows immediately afterwards.
- R5: The fetch address is (segment × 16 + offset) modulo 2^20. The offset itself wraps within 16 bits as it advances.
- R6: When the store is full and no operand request is present, `bus_req` stays low.
- R7: When the store is empty, `q_valid` is low. A byte can appear only in the cycle after a bus completion.
- R8: A `flush` empties the store by the next cycle, with `q_valid` low. A pop in the same cycle is ignored. Fetching restarts at (`flush_seg`, `flush_off`).
- R9: A fetch from an odd offset asserts `bus_byte` and reads one byte from `bus_rdata[15:8]`. It advances the offset by 1, and the next fetch is a word fetch.
- R10: The data of a fetch that was in flight when a flush arrived is discarded. That data does not enter the store and does not advance the offset.
- R11: After reset the store is empty and the first fetch is taken from (RESET_SEG, RESET_OFF).
- R12: An operand cycle presents `op_addr`, `op_we` and `op_wdata` on the bus. `op_done` pulses together with `bus_done`, and `op_rdata` carries `bus_rdata` during that pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | One-cycle control transfer strobe |
| flush_seg | input | 16 | New code segment for the transfer |
| flush_off | input | 16 | New fetch offset for the transfer |
| q_valid | output | 1 | Output byte is valid |
| q_byte | output | 8 | Oldest queued instruction byte |
| q_pop | input | 1 | Consume the output byte |
| op_req | input | 1 | Operand access request, held until `op_done` |
| op_we | input | 1 | Operand access is a write |
| op_addr | input | 20 | Operand physical address |
| op_wdata | input | 16 | Operand write data |
| op_done | output | 1 | Operand cycle completes this cycle |
| op_rdata | output | 16 | Operand read data, valid with `op_done` |
| bus_req | output | 1 | Bus cycle requested |
| bus_addr | output | 20 | Bus cycle address |
| bus_we | output | 1 | Bus cycle is a write |
| bus_byte | output | 1 | Single-byte fetch at odd address |
| bus_wdata | output | 16 | Bus write data |
| bus_done | input | 1 | Bus cycle completion pulse |
| bus_rdata | input | 16 | Bus read data, valid with `bus_done` |

## Verification
Each result has a fixed delay after its stimulus:

- A bus cycle starts on the edge after the cycle in which it was decided, so `bus_req` and `bus_addr` are first visible one cycle after the store reaches two free slots or `op_req` is raised.
- Fetched bytes show at `q_valid` one cycle after the `bus_done` pulse.
- `op_done` and `op_rdata` appear in the same cycle as `bus_done`.
- A flush shows an empty store on the next cycle.

The bench drives and samples one time unit after the falling edge. It waits on these visible events, `bus_req`, `bus_done` and `q_valid`, rather than counting fixed cycle totals, so each check reads the value in the cycle where it is due. The memory model answers after a fixed latency, which lets the ordering checks put an operand cycle directly behind a fetch that is still running.

// File: rtl/pfq_pkg.sv
package pfq_pkg;

  localparam int SEG_W  = 16;
  localparam int OFF_W  = 16;
  localparam int ADDR_W = 20;
  localparam int WORD_W = 16;
  localparam int SHIFT  = ADDR_W - SEG_W;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_FETCH = 2'd1,
    SQ_OPER  = 2'd2
  } seq_state_t;

  // Segment times 16 plus offset, truncated to the address width.
  function automatic logic [ADDR_W-1:0] phys_addr(
    input logic [SEG_W-1:0] seg,
    input logic [OFF_W-1:0] off
  );
    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] disp;
    base = {seg, {SHIFT{1'b0}}};
    disp = {{(ADDR_W-OFF_W){1'b0}}, off};
    return base + disp;
  endfunction

endpackage

// File: rtl/pfq_buffer.sv
module pfq_buffer #(
  parameter int DEPTH = 6,
  parameter int PTR_W = $clog2(DEPTH),
  parameter int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic [1:0]       push_n,
  input  logic [7:0]       push_lo,
  input  logic [7:0]       push_hi,
  input  logic             pop,
  output logic             out_valid,
  output logic [7:0]       out_byte,
  output logic [LVL_W-1:0] level
);

  logic [7:0]       slot [DEPTH];
  logic [PTR_W-1:0] rd_ptr;
  logic [PTR_W-1:0] wr_ptr;
  logic [PTR_W-1:0] wr_next;
  logic             pop_taken;

  function automatic logic [PTR_W-1:0] wrap_add(
    input logic [PTR_W-1:0] ptr,
    input logic [1:0]       n
  );
    logic [PTR_W:0] sum;
    sum = {1'b0, ptr} + (PTR_W+1)'(n);
    if (sum >= (PTR_W+1)'(DEPTH)) sum = sum - (PTR_W+1)'(DEPTH);
    return sum[PTR_W-1:0];
  endfunction

  assign wr_next   = wrap_add(wr_ptr, 2'd1);
  assign pop_taken = pop && (level != '0) && !clear;
  assign out_valid = (level != '0);
  assign out_byte  = slot[rd_ptr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      level  <= '0;
    end else if (clear) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      level  <= '0;
    end else begin
      wr_ptr <= wrap_add(wr_ptr, push_n);
      if (pop_taken) rd_ptr <= wrap_add(rd_ptr, 2'd1);
      level <= level + LVL_W'(push_n) - LVL_W'(pop_taken);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) slot[i] <= '0;
    end else if (!clear) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (push_n != 2'd0 && wr_ptr == PTR_W'(i))
          slot[i] <= push_lo;
        else if (push_n == 2'd2 && wr_next == PTR_W'(i))
          slot[i] <= push_hi;
      end
    end
  end

endmodule

// File: rtl/pfq_ptr.sv
module pfq_ptr #(
  parameter logic [15:0] RESET_SEG = 16'hF000,
  parameter logic [15:0] RESET_OFF = 16'hFFF0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load,
  input  logic [15:0] load_seg,
  input  logic [15:0] load_off,
  input  logic [1:0]  step,
  output logic [15:0] cs,
  output logic [15:0] ip
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cs <= RESET_SEG;
      ip <= RESET_OFF;
    end else if (load) begin
      cs <= load_seg;
      ip <= load_off;
    end else begin
      ip <= ip + 16'(step);
    end
  end

endmodule

// File: rtl/pfq_seq.sv
module pfq_seq
  import pfq_pkg::*;
#(
  parameter int DEPTH = 6,
  parameter int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic [LVL_W-1:0]  level,
  input  logic              op_req,
  input  logic              op_we,
  input  logic [ADDR_W-1:0] op_addr,
  input  logic [WORD_W-1:0] op_wdata,
  input  logic [SEG_W-1:0]  cs,
  input  logic [OFF_W-1:0]  ip,
  input  logic              bus_done,
  input  logic [WORD_W-1:0] bus_rdata,
  output logic              bus_req,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_we,
  output logic              bus_byte,
  output logic [WORD_W-1:0] bus_wdata,
  output logic              op_done,
  output logic [WORD_W-1:0] op_rdata,
  output logic [1:0]        push_n,
  output logic [7:0]        push_lo,
  output logic [7:0]        push_hi,
  output logic              in_fetch,
  output logic              fetch_start,
  output logic              fetch_end
);

  seq_state_t        state_q;
  logic [ADDR_W-1:0] addr_q;
  logic              we_q;
  logic              byte_q;
  logic [WORD_W-1:0] wdata_q;
  logic              drop_q;
  logic              room;
  logic              op_start;
  logic              keep;

  assign room        = (level <= LVL_W'(DEPTH - 2));
  assign op_start    = (state_q == SQ_IDLE) && op_req;
  assign fetch_start = (state_q == SQ_IDLE) && !op_req && !flush && room;
  assign in_fetch    = (state_q == SQ_FETCH);
  assign fetch_end   = in_fetch && bus_done;
  assign keep        = fetch_end && !drop_q && !flush;

  assign push_n  = keep ? (byte_q ? 2'd1 : 2'd2) : 2'd0;
  assign push_lo = byte_q ? bus_rdata[15:8] : bus_rdata[7:0];
  assign push_hi = bus_rdata[15:8];

  assign bus_req   = (state_q != SQ_IDLE);
  assign bus_addr  = addr_q;
  assign bus_we    = we_q;
  assign bus_byte  = byte_q;
  assign bus_wdata = wdata_q;
  assign op_done   = (state_q == SQ_OPER) && bus_done;
  assign op_rdata  = bus_rdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      addr_q  <= '0;
      we_q    <= 1'b0;
      byte_q  <= 1'b0;
      wdata_q <= '0;
      drop_q  <= 1'b0;
    end else begin
      unique case (state_q)
        SQ_IDLE: begin
          drop_q <= 1'b0;
          if (op_start) begin
            state_q <= SQ_OPER;
            addr_q  <= op_addr;
            we_q    <= op_we;
            wdata_q <= op_wdata;
            byte_q  <= 1'b0;
          end else if (fetch_start) begin
            state_q <= SQ_FETCH;
            addr_q  <= phys_addr(cs, ip);
            we_q    <= 1'b0;
            byte_q  <= ip[0];
          end
        end
        SQ_FETCH: begin
          if (bus_done) begin
            state_q <= SQ_IDLE;
            drop_q  <= 1'b0;
          end else if (flush) begin
            drop_q  <= 1'b1;
          end
        end
        SQ_OPER: begin
          if (bus_done) state_q <= SQ_IDLE;
        end
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/prefetch_queue.sv
module prefetch_queue #(
  parameter int          DEPTH     = 6,
  parameter logic [15:0] RESET_SEG = 16'hF000,
  parameter logic [15:0] RESET_OFF = 16'hFFF0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        flush,
  input  logic [15:0] flush_seg,
  input  logic [15:0] flush_off,
  output logic        q_valid,
  output logic [7:0]  q_byte,
  input  logic        q_pop,
  input  logic        op_req,
  input  logic        op_we,
  input  logic [19:0] op_addr,
  input  logic [15:0] op_wdata,
  output logic        op_done,
  output logic [15:0] op_rdata,
  output logic        bus_req,
  output logic [19:0] bus_addr,
  output logic        bus_we,
  output logic        bus_byte,
  output logic [15:0] bus_wdata,
  input  logic        bus_done,
  input  logic [15:0] bus_rdata
);

  localparam int PTR_W = $clog2(DEPTH);
  localparam int LVL_W = $clog2(DEPTH + 1);

  // Internal events brought out for the checker.
  logic [LVL_W-1:0] fill_level;
  logic [1:0]       push_n;
  logic [7:0]       push_lo;
  logic [7:0]       push_hi;
  logic [15:0]      cs;
  logic [15:0]      ip;
  logic             in_fetch;
  logic             fetch_start;
  logic             fetch_end;

  pfq_ptr #(
    .RESET_SEG(RESET_SEG),
    .RESET_OFF(RESET_OFF)
  ) u_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (flush),
    .load_seg (flush_seg),
    .load_off (flush_off),
    .step     (push_n),
    .cs       (cs),
    .ip       (ip)
  );

  pfq_buffer #(
    .DEPTH(DEPTH),
    .PTR_W(PTR_W),
    .LVL_W(LVL_W)
  ) u_buf (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (flush),
    .push_n    (push_n),
    .push_lo   (push_lo),
    .push_hi   (push_hi),
    .pop       (q_pop),
    .out_valid (q_valid),
    .out_byte  (q_byte),
    .level     (fill_level)
  );

  pfq_seq #(
    .DEPTH(DEPTH),
    .LVL_W(LVL_W)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .flush       (flush),
    .level       (fill_level),
    .op_req      (op_req),
    .op_we       (op_we),
    .op_addr     (op_addr),
    .op_wdata    (op_wdata),
    .cs          (cs),
    .ip          (ip),
    .bus_done    (bus_done),
    .bus_rdata   (bus_rdata),
    .bus_req     (bus_req),
    .bus_addr    (bus_addr),
    .bus_we      (bus_we),
    .bus_byte    (bus_byte),
    .bus_wdata   (bus_wdata),
    .op_done     (op_done),
    .op_rdata    (op_rdata),
    .push_n      (push_n),
    .push_lo     (push_lo),
    .push_hi     (push_hi),
    .in_fetch    (in_fetch),
    .fetch_start (fetch_start),
    .fetch_end   (fetch_end)
  );

endmodule

// File: rtl/pfq_checker.sv
module pfq_checker #(
  parameter int DEPTH = 6,
  parameter int LVL_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             flush,
  input logic             op_req,
  input logic             q_valid,
  input logic             bus_req,
  input logic             bus_done,
  input logic             bus_byte,
  input logic             op_done,
  input logic [19:0]      bus_addr,
  input logic [LVL_W-1:0] level,
  input logic             in_fetch,
  input logic [15:0]      cs,
  input logic [15:0]      ip
);

  logic drop_pend;

  always_ff @(posedge clk) begin
    if (!rst_n)                    drop_pend <= 1'b0;
    else if (in_fetch && bus_done) drop_pend <= 1'b0;
    else if (in_fetch && flush)    drop_pend <= 1'b1;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LVL_W'(DEPTH)); // R1

  AST_FETCH_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_fetch) |-> ($past(level) <= LVL_W'(DEPTH - 2)) && !$past(op_req)); // R2

  AST_FETCH_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
    in_fetch && !bus_done |=> in_fetch && $stable(bus_addr)); // R4

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_done |=> bus_req); // R4

  AST_FETCH_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_fetch) |-> bus_addr == pfq_pkg::phys_addr($past(cs), $past(ip))); // R5

  AST_FULL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_req && level == LVL_W'(DEPTH) && !op_req |=> !bus_req); // R6

  AST_EMPTY_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
    !q_valid && !bus_done |=> !q_valid); // R7

  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !q_valid); // R8

  AST_ODD_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    in_fetch |-> bus_byte == bus_addr[0]); // R9

  AST_DROP_STALE: assert property (@(posedge clk) disable iff (!rst_n)
    drop_pend && bus_done |=> !q_valid); // R10

  AST_OP_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    op_done |-> bus_done && bus_req && !in_fetch); // R12

endmodule

bind prefetch_queue pfq_checker #(
  .DEPTH(DEPTH),
  .LVL_W(LVL_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .flush    (flush),
  .op_req   (op_req),
  .q_valid  (q_valid),
  .bus_req  (bus_req),
  .bus_done (bus_done),
  .bus_byte (bus_byte),
  .op_done  (op_done),
  .bus_addr (bus_addr),
  .level    (fill_level),
  .in_fetch (in_fetch),
  .cs       (cs),
  .ip       (ip)
);

// File: tb/prefetch_queue_test.sv
`timescale 1ns/100ps
module prefetch_queue_test;

  localparam int          DEPTH = 6;
  localparam logic [15:0] RSEG  = 16'hF000;
  localparam logic [15:0] ROFF  = 16'hFFF0;
  localparam int          LAT   = 2;
  localparam int          NVEC  = 5;
  // {segment, offset, bytes to pop}
  localparam logic [39:0] VEC [NVEC] = '{
    {16'h1000, 16'h0000, 8'd9},
    {16'h2345, 16'h0011, 8'd7},
    {16'hFFFF, 16'h0008, 8'd12},
    {16'h0000, 16'hFFFE, 8'd5},
    {16'hABCD, 16'h1235, 8'd6}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic [15:0] flush_seg = '0;
  logic [15:0] flush_off = '0;
  logic        q_valid;
  logic [7:0]  q_byte;
  logic        q_pop = 1'b0;
  logic        op_req = 1'b0;
  logic        op_we = 1'b0;
  logic [19:0] op_addr = '0;
  logic [15:0] op_wdata = '0;
  logic        op_done;
  logic [15:0] op_rdata;
  logic        bus_req;
  logic [19:0] bus_addr;
  logic        bus_we;
  logic        bus_byte;
  logic [15:0] bus_wdata;
  logic        bus_done = 1'b0;
  logic [15:0] bus_rdata = '0;

  logic [19:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  int          lat_cnt = 0;
  int          checks = 0;
  int          errors = 0;

  always #2.5 clk = ~clk;

  prefetch_queue #(
    .DEPTH(DEPTH), .RESET_SEG(RSEG), .RESET_OFF(ROFF)
  ) uut (
    .clk(clk), .rst_n(rst_n), .flush(flush), .flush_seg(flush_seg),
    .flush_off(flush_off), .q_valid(q_valid), .q_byte(q_byte), .q_pop(q_pop),
    .op_req(op_req), .op_we(op_we), .op_addr(op_addr), .op_wdata(op_wdata),
    .op_done(op_done), .op_rdata(op_rdata), .bus_req(bus_req),
    .bus_addr(bus_addr), .bus_we(bus_we), .bus_byte(bus_byte),
    .bus_wdata(bus_wdata), .bus_done(bus_done), .bus_rdata(bus_rdata)
  );

  function automatic logic [19:0] lin(input logic [15:0] s, input int o);
    int a;
    a = (int'(s) * 16 + (o % 65536)) % 1048576;
    return a[19:0];
  endfunction

  function automatic logic [7:0] mbyte(input logic [19:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ {a[19:16], 4'hA};
  endfunction

  function automatic logic [15:0] mword(input logic [19:0] a);
    return {mbyte({a[19:1], 1'b1}), mbyte({a[19:1], 1'b0})};
  endfunction

  // Memory model: completes each bus cycle LAT falling edges after request.
  always @(negedge clk) begin
    if (!rst_n) begin
      bus_done <= 1'b0;
      lat_cnt  <= 0;
    end else if (bus_done) begin
      bus_done <= 1'b0;
      lat_cnt  <= 0;
    end else if (bus_req) begin
      if (lat_cnt == LAT - 1) begin
        bus_done  <= 1'b1;
        bus_rdata <= mword(bus_addr);
        if (bus_we) begin
          wr_addr <= bus_addr;
          wr_data <= bus_wdata;
        end
      end else begin
        lat_cnt <= lat_cnt + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic pop_check(input logic [19:0] a, input string tag);
    for (int k = 0; k < 200 && !q_valid; k++) step();
    chk(q_valid && q_byte == mbyte(a), tag, {23'd0, q_valid, q_byte}, {24'd1, mbyte(a)});
    q_pop = 1'b1;
    step();
    q_pop = 1'b0;
  endtask

  task automatic do_flush(input logic [15:0] s, input logic [15:0] o, input bit with_pop);
    q_pop = with_pop & q_valid;
    flush = 1'b1;
    flush_seg = s;
    flush_off = o;
    step();
    flush = 1'b0;
    q_pop = 1'b0;
    chk(!q_valid, "R8 queue empty after flush", {31'd0, q_valid}, 32'd0);
  endtask

  task automatic wait_req();
    for (int k = 0; k < 200 && !bus_req; k++) step();
  endtask

  task automatic wait_done();
    for (int k = 0; k < 200 && !bus_done; k++) step();
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 400 && bus_req; k++) step();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R1..: actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    bit quiet;
    logic [19:0] a0;
    // R11: reset state
    repeat (4) step();
    chk(!q_valid && !bus_req, "R11 reset outputs", {30'd0, q_valid, bus_req}, 32'd0);
    rst_n = 1'b1;
    wait_req();
    chk(bus_addr == lin(RSEG, ROFF), "R11 R5 first fetch address", {12'd0, bus_addr},
        {12'd0, lin(RSEG, ROFF)});

    // R6: full queue with no pops leaves the bus idle
    repeat (60) step();
    quiet = 1'b1;
    for (int k = 0; k < 10; k++) begin
      if (bus_req) quiet = 1'b0;
      step();
    end
    chk(quiet, "R6 bus idle when full", {31'd0, !quiet}, 32'd0);

    // R1: order; R2: a single free slot does not start a fetch
    pop_check(lin(RSEG, ROFF), "R1 first byte");
    quiet = 1'b1;
    for (int k = 0; k < 10; k++) begin
      if (bus_req) quiet = 1'b0;
      step();
    end
    chk(quiet, "R2 one free byte keeps bus idle", {31'd0, !quiet}, 32'd0);
    for (int i = 1; i < 8; i++) pop_check(lin(RSEG, int'(ROFF) + i), "R1 R3 byte order");

    // R5 R8 R9 R3: vector table of flush targets
    for (int v = 0; v < NVEC; v++) begin
      logic [15:0] s;
      logic [15:0] o;
      int          n;
      s = VEC[v][39:24];
      o = VEC[v][23:8];
      n = int'(VEC[v][7:0]);
      do_flush(s, o, 1'b1);
      for (int i = 0; i < n; i++) pop_check(lin(s, int'(o) + i), "R5 R8 vector stream");
    end

    // R4 R12: operand request during a fetch waits for it, then runs first
    wait_idle();
    do_flush(16'h0400, 16'h0020, 1'b0);
    wait_req();
    op_req = 1'b1;
    op_we = 1'b0;
    op_addr = 20'h3_1234;
    wait_done();
    chk(bus_addr == lin(16'h0400, 16'h0020) && !op_done, "R4 fetch completes first",
        {12'd0, bus_addr}, {12'd0, lin(16'h0400, 16'h0020)});
    step();
    wait_done();
    chk(op_done && bus_addr == 20'h3_1234 && !bus_we, "R2 R12 operand read cycle",
        {11'd0, op_done, bus_addr}, {11'd1, 20'h3_1234});
    chk(op_rdata == mword(20'h3_1234), "R12 operand read data", {16'd0, op_rdata},
        {16'd0, mword(20'h3_1234)});
    op_req = 1'b0;
    step();
    wait_idle();
    op_req = 1'b1;
    op_we = 1'b1;
    op_addr = 20'h0_5556;
    op_wdata = 16'hBEEF;
    wait_done();
    op_req = 1'b0;
    op_we = 1'b0;
    chk(op_done && wr_addr == 20'h0_5556 && wr_data == 16'hBEEF, "R12 operand write",
        {wr_addr[15:0], wr_data}, {16'h5556, 16'hBEEF});
    step();

    // R10: in-flight fetch discarded by a second flush
    for (int i = 0; i < 6; i++) if (q_valid) pop_check(lin(16'h0400, 16'h0020 + i), "R1 drain");
    wait_idle();
    do_flush(16'h7000, 16'h0100, 1'b0);
    wait_req();
    a0 = bus_addr;
    do_flush(16'h0123, 16'h0040, 1'b0);
    chk(a0 == lin(16'h7000, 16'h0100), "R10 first target was on the bus", {12'd0, a0},
        {12'd0, lin(16'h7000, 16'h0100)});
    for (int i = 0; i < 4; i++) pop_check(lin(16'h0123, 16'h0040 + i), "R10 stale data dropped");

    // R9: odd offset fetches one byte, then realigns
    wait_idle();
    do_flush(16'h0200, 16'h0033, 1'b0);
    wait_req();
    chk(bus_byte && bus_addr == lin(16'h0200, 16'h0033), "R9 single byte fetch",
        {11'd0, bus_byte, bus_addr}, {11'd1, lin(16'h0200, 16'h0033)});
    wait_done();
    step();
    wait_req();
    chk(!bus_byte && bus_addr == lin(16'h0200, 16'h0034), "R9 next fetch is word aligned",
        {11'd0, bus_byte, bus_addr}, {11'd0, lin(16'h0200, 16'h0034)});
    for (int i = 0; i < 5; i++) pop_check(lin(16'h0200, 16'h0033 + i), "R9 R3 bytes after realign");

    // R7: empty queue shows nothing valid while the bus is idle
    q_pop = 1'b0;
    op_req = 1'b1;
    op_we = 1'b0;
    op_addr = 20'h0_0010;
    wait_idle();
    do_flush(16'h0300, 16'h0000, 1'b0);
    chk(!q_valid, "R7 empty queue has no valid byte", {31'd0, q_valid}, 32'd0);
    wait_done();
    op_req = 1'b0;
    step();
    chk(!q_valid, "R7 no byte after operand only", {31'd0, q_valid}, 32'd0);
    pop_check(lin(16'h0300, 16'h0000), "R7 R2 fetch after operand");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule